// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a small CPU and decides when and where the processor is diverted into an interrupt handler. Each source is configured at elaboration time as either a flagged source, whose event is captured in a pending flag that survives until it is serviced or cleared, or a level source, which asks for service only while its input is held high. The controller masks pending sources with per-source enables and a single global enable bit. It presents the highest-priority request to the CPU together with the vector index and the vector's program address.

The CPU accepts a request by pulsing `ack`. On that edge the global enable drops and the flag of the taken flagged source is cleared. A return-from-interrupt pulse turns the global enable back on. The controller then withholds any new request until the CPU reports one completed main-program instruction, so a stream of pending interrupts cannot starve the interrupted code. Software can set or clear the global enable and can clear any flag by writing a one to its bit. A relocation input moves the whole vector table from address zero to a boot-area base.

Top module: `prio_irq_ctrl`

## Requirements
- R1: `irq_req` is high only when some source is pending, that source's bit in `src_en` is 1 and `gie` is 1. A pending, enabled source with `gie` at 0 gives no request.
- R2: Source bit i (0-based) is reported as vector index i+1, and the lowest index among enabled pending sources wins. Index 0 is reserved for reset and is output, with `irq_req` low, when nothing is eligible.
- R3: A clock edge with `irq_req` and `ack` both high takes the interrupt, and `gie` reads 0 after it. `ack` while `irq_req` is low changes nothing.
- R4: `reti` or `gie_set` sets `gie` at the next edge. `gie_clr` clears it and wins over `reti`, `gie_set` and a take in the same cycle.
- R5: Taking a flagged source clears that source's flag and no other flag.
- R6: While `sw_clr_wr` is high, each 1 in `sw_clr_data` clears the matching flag and each 0 leaves it as it was. An event arriving in the same cycle as a clear leaves the flag set.
- R7: A flagged event seen while its enable or `gie` is off stays in `flags`, and it is requested, in priority order, once both enables are on.
- R8: Level sources are bits 6 and 7 by default (parameter `LEVEL_MASK`). They request in the same cycle their input is high, never set a bit in `flags`, and are lost if the input falls before they are enabled.
- R9: After an edge with `reti` high, `irq_req` stays low until the edge that ends a cycle with `instr_done` high, and it may rise only after that edge.
- R10: In a cycle with `gie_clr` high, `irq_req` is low in that same cycle, even for a source that became eligible in that cycle.
- R11: `irq_addr` equals base + 2 × `irq_idx`, where base is 0 with `vec_reloc` low and `BOOT_BASE` (default 0x3800) with it high.
- R12: During and right after reset, `gie`, `flags`, `irq_req` and `irq_idx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_SRC | Source events (flagged) or conditions (level) |
| src_en | input | NUM_SRC | Per-source enables |
| sw_clr_wr | input | 1 | Software flag-clear strobe |
| sw_clr_data | input | NUM_SRC | Write-one-to-clear mask |
| gie_set | input | 1 | Software sets global enable |
| gie_clr | input | 1 | Software clears global enable |
| reti | input | 1 | Return-from-interrupt pulse |
| instr_done | input | 1 | CPU completed one instruction this cycle |
| ack | input | 1 | CPU takes the offered vector |
| vec_reloc | input | 1 | Selects the boot-area vector base |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_idx | output | IDX_W | Vector index of the winning source |
| irq_addr | output | ADDR_W | Program address of that vector |
| gie | output | 1 | Global enable state |
| flags | output | NUM_SRC | Pending flags of flagged sources |

## Verification
A flag lost or stuck in the wrong state shows on `flags` the cycle after the edge that should have changed it. When that source is enabled, it also shows as a wrong `irq_idx` or a request that is missing or extra. A wrong global-enable or hold state shows at once as `irq_req` rising or staying low in the cycles right after a take, a return or a software clear. Address errors show combinationally on `irq_addr` for every index the bench drives, under both table bases.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

   // kind of request line behind each source position
   typedef enum logic {
      SRC_FLAGGED = 1'b0,
      SRC_LEVEL   = 1'b1
   } src_kind_t;

   // width needed to hold vector indices 0..n_src (0 is the reset slot)
   function automatic int idx_width(input int n_src);
      return (n_src < 1) ? 1 : $clog2(n_src + 1);
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/prio_irq_flag.sv
// One latched pending flag for a flagged source.
module prio_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic hw_clr,
   input  logic sw_clr,
   output logic flag
);

   logic flag_q;

   // a new event wins over either kind of clear in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= evt | (flag_q & ~hw_clr & ~sw_clr);
   end

   assign flag = flag_q;

   // R7: a flag is held until something clears it
   assert_flag_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !hw_clr && !sw_clr) |=> flag);

   // R5: hardware acknowledge without a fresh event empties the flag
   assert_hw_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_clr && !evt) |=> !flag);

   // R6: software clear without a fresh event empties the flag
   assert_sw_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_clr && !evt) |=> !flag);

endmodule

// File: rtl/prio_irq_pick.sv
// Fixed-priority selection: lowest bit position wins.
module prio_irq_pick #(
   parameter int NUM_SRC = 8,
   parameter int IDX_W   = prio_irq_pkg::idx_width(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] pend,
   output logic [NUM_SRC-1:0] grant,
   output logic               any,
   output logic [IDX_W-1:0]   idx
);

   always_comb begin
      grant = '0;
      idx   = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (pend[i]) begin
            grant = '0;
            grant[i] = 1'b1;
            idx = IDX_W'(i + 1);
         end
      end
   end

   assign any = |pend;

   // R2: at most one winner, and a winner exists whenever something pends
   assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && (any == (grant != '0)));

   // R2: reset slot is reported only when nothing is pending
   assert_idx_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (idx == '0) == !any);

endmodule

// File: rtl/prio_irq_gate.sv
// Global enable, post-return hold and request gating.
module prio_irq_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic any_pend,
   input  logic ack,
   input  logic gie_set,
   input  logic gie_clr,
   input  logic reti,
   input  logic instr_done,
   output logic gie,
   output logic irq_req,
   output logic take
);

   logic gie_q;
   logic hold_q;

   // software clear is honoured in its own cycle
   assign irq_req = gie_q & ~gie_clr & ~hold_q & any_pend;
   assign take    = irq_req & ack;
   assign gie     = gie_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gie_q  <= 1'b0;
         hold_q <= 1'b0;
      end else begin
         if (gie_clr || take)      gie_q <= 1'b0;
         else if (reti || gie_set) gie_q <= 1'b1;

         if (reti)            hold_q <= 1'b1;
         else if (instr_done) hold_q <= 1'b0;
      end
   end

   // R3: entry drops the global enable
   assert_entry_clears_gie_R3: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !gie);

   // R4: return re-arms the global enable unless software clears it
   assert_reti_sets_gie_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && !gie_clr && !take) |=> gie);

   // R9: no request in the cycle after a return
   assert_reti_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      reti |=> !irq_req);

   // R9: hold persists until an instruction completes
   assert_hold_until_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_req && !instr_done && $past(reti)) |=> !irq_req);

   // R10: software clear suppresses the request immediately
   assert_clr_now_R10: assert property (@(posedge clk) disable iff (!rst_n)
      gie_clr |-> !irq_req);

endmodule

// File: rtl/prio_irq_vecaddr.sv
// Vector address: base + VEC_WORDS * index.
module prio_irq_vecaddr #(
   parameter int          IDX_W     = 4,
   parameter int          ADDR_W    = 16,
   parameter int          VEC_WORDS = 2,
   parameter logic [ADDR_W-1:0] BOOT_BASE = 16'h3800
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic              reloc,
   output logic [ADDR_W-1:0] addr
);

   localparam logic [ADDR_W-1:0] LOW_BASE = '0;
   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] offset;

   assign base = reloc ? BOOT_BASE : LOW_BASE;

   generate
      if (prio_irq_pkg::is_pow2(VEC_WORDS)) begin : g_shift
         localparam int SHIFT = $clog2(VEC_WORDS);
         assign offset = ADDR_W'(idx) << SHIFT;
      end else begin : g_mult
         localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(VEC_WORDS);
         assign offset = ADDR_W'(idx) * STRIDE;
      end
   endgenerate

   assign addr = base + offset;

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int                NUM_SRC    = 8,
   parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'hC0,
   parameter int                ADDR_W     = 16,
   parameter int                VEC_WORDS  = 2,
   parameter logic [ADDR_W-1:0] BOOT_BASE  = 16'h3800,
   parameter int                IDX_W      = prio_irq_pkg::idx_width(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_in,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic               sw_clr_wr,
   input  logic [NUM_SRC-1:0] sw_clr_data,
   input  logic               gie_set,
   input  logic               gie_clr,
   input  logic               reti,
   input  logic               instr_done,
   input  logic               ack,
   input  logic               vec_reloc,
   output logic               irq_req,
   output logic [IDX_W-1:0]   irq_idx,
   output logic [ADDR_W-1:0]  irq_addr,
   output logic               gie,
   output logic [NUM_SRC-1:0] flags
);
   import prio_irq_pkg::*;

   localparam longint TABLE_END = longint'(BOOT_BASE) + longint'(NUM_SRC + 1) * VEC_WORDS;

   // elaboration-time parameter checks
   generate
      if (NUM_SRC < 1 || NUM_SRC > 64) begin : g_bad_num
         $error("NUM_SRC must be in 1..64");
      end
      if (VEC_WORDS < 1) begin : g_bad_words
         $error("VEC_WORDS must be at least 1");
      end
      if (IDX_W < idx_width(NUM_SRC)) begin : g_bad_idx
         $error("IDX_W too narrow for NUM_SRC");
      end
      if (TABLE_END > (longint'(1) << ADDR_W)) begin : g_bad_addr
         $error("vector table does not fit ADDR_W");
      end
   endgenerate

   logic [NUM_SRC-1:0] raw_pend;
   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] grant;
   logic               any_pend;
   logic               take;

   // per-source variant chosen by LEVEL_MASK
   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         if (LEVEL_MASK[i] == SRC_LEVEL) begin : g_level
            logic unused_lvl;
            assign unused_lvl  = sw_clr_data[i];
            assign raw_pend[i] = src_in[i];
            assign flags[i]    = 1'b0;
         end else begin : g_flag
            prio_irq_flag u_flag (
               .clk    (clk),
               .rst_n  (rst_n),
               .evt    (src_in[i]),
               .hw_clr (take & grant[i]),
               .sw_clr (sw_clr_wr & sw_clr_data[i]),
               .flag   (flags[i])
            );
            assign raw_pend[i] = flags[i];
         end
      end
   endgenerate

   assign pend = raw_pend & src_en;

   prio_irq_pick #(
      .NUM_SRC (NUM_SRC),
      .IDX_W   (IDX_W)
   ) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .pend  (pend),
      .grant (grant),
      .any   (any_pend),
      .idx   (irq_idx)
   );

   prio_irq_gate u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .any_pend   (any_pend),
      .ack        (ack),
      .gie_set    (gie_set),
      .gie_clr    (gie_clr),
      .reti       (reti),
      .instr_done (instr_done),
      .gie        (gie),
      .irq_req    (irq_req),
      .take       (take)
   );

   prio_irq_vecaddr #(
      .IDX_W     (IDX_W),
      .ADDR_W    (ADDR_W),
      .VEC_WORDS (VEC_WORDS),
      .BOOT_BASE (BOOT_BASE)
   ) u_vec (
      .idx   (irq_idx),
      .reloc (vec_reloc),
      .addr  (irq_addr)
   );

   // R1: a request always names an enabled source
   assert_req_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_idx != '0) && src_en[int'(irq_idx) - 1]);

   // R8: level sources never leave a latched flag
   assert_level_no_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flags & LEVEL_MASK) == '0);

   // R12: first cycle after reset is quiet
   assert_reset_quiet_R12: assert property (@(posedge clk)
      $rose(rst_n) |-> (!gie && flags == '0 && !irq_req));

endmodule

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;

   localparam int N = 8;
   localparam logic [7:0] LVL = 8'hC0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] src_in = '0, src_en = '0, sw_clr_data = '0;
   logic sw_clr_wr = 0, gie_set = 0, gie_clr = 0, reti = 0, instr_done = 0, ack = 0, vec_reloc = 0;
   logic irq_req, gie;
   logic [3:0] irq_idx;
   logic [15:0] irq_addr;
   logic [N-1:0] flags;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk;

   prio_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .src_en(src_en),
      .sw_clr_wr(sw_clr_wr), .sw_clr_data(sw_clr_data), .gie_set(gie_set),
      .gie_clr(gie_clr), .reti(reti), .instr_done(instr_done), .ack(ack),
      .vec_reloc(vec_reloc), .irq_req(irq_req), .irq_idx(irq_idx),
      .irq_addr(irq_addr), .gie(gie), .flags(flags)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // inputs change 1 ns after a rising edge
   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic clean();
      src_in = '0; src_en = '0; ack = 0; reti = 0; instr_done = 0; gie_clr = 0;
      sw_clr_wr = 1; sw_clr_data = '1; gie_set = 1;
      tick();
      sw_clr_wr = 0; sw_clr_data = '0; gie_set = 0;
   endtask

   // {pattern, enables, reloc, exp_req, exp_idx, exp_addr}
   localparam logic [37:0] TBL [10] = '{
      {8'h01, 8'hFF, 1'b0, 1'b1, 4'd1, 16'h0002},
      {8'h06, 8'hFF, 1'b0, 1'b1, 4'd2, 16'h0004},
      {8'h06, 8'hFD, 1'b1, 1'b1, 4'd3, 16'h3806},
      {8'h80, 8'hFF, 1'b0, 1'b1, 4'd8, 16'h0010},
      {8'hC0, 8'h7F, 1'b1, 1'b1, 4'd7, 16'h380E},
      {8'h90, 8'hEF, 1'b0, 1'b1, 4'd8, 16'h0010},
      {8'h00, 8'hFF, 1'b0, 1'b0, 4'd0, 16'h0000},
      {8'h30, 8'h00, 1'b0, 1'b0, 4'd0, 16'h0000},
      {8'hFF, 8'hFF, 1'b1, 1'b1, 4'd1, 16'h3802},
      {8'h28, 8'hF7, 1'b0, 1'b1, 4'd6, 16'h000C}
   };

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      // R12 reset state
      tick(); tick();
      check("R12 gie in reset", gie, 0);
      check("R12 req in reset", irq_req, 0);
      rst_n = 1;
      tick();
      check("R12 gie after reset", gie, 0);
      check("R12 flags after reset", flags, 0);
      check("R12 idx after reset", irq_idx, 0);

      // table: R2 priority, R11 addresses, R8 level sources
      for (int k = 0; k < 10; k++) begin
         clean();
         src_in = TBL[k][37:30];
         tick();
         src_in = TBL[k][37:30] & LVL;
         src_en = TBL[k][29:22];
         vec_reloc = TBL[k][21];
         #1;
         check($sformatf("R2 req entry %0d", k), irq_req, TBL[k][20]);
         check($sformatf("R2 idx entry %0d", k), irq_idx, TBL[k][19:16]);
         check($sformatf("R11 addr entry %0d", k), irq_addr, TBL[k][15:0]);
      end
      vec_reloc = 0;

      // R7 latched while disabled, R1 gie gating
      clean();
      gie_clr = 1; tick(); gie_clr = 0;
      src_in = 8'h12; tick(); src_in = 0;
      check("R7 flags latched", flags, 8'h12);
      src_en = 8'hFF; #1;
      check("R1 no req with gie off", irq_req, 0);
      gie_set = 1; tick(); gie_set = 0;
      check("R7 served in order idx", irq_idx, 2);
      check("R1 req with gie on", irq_req, 1);

      // R3 take, R5 flag clear
      ack = 1; tick(); ack = 0;
      check("R3 gie cleared on take", gie, 0);
      check("R5 only taken flag cleared", flags, 8'h10);
      check("R3 no req after take", irq_req, 0);

      // R9 one instruction after return
      reti = 1; tick(); reti = 0;
      check("R4 reti sets gie", gie, 1);
      check("R9 held after reti", irq_req, 0);
      tick();
      check("R9 still held without instr", irq_req, 0);
      instr_done = 1; #1;
      check("R9 held during instr cycle", irq_req, 0);
      tick(); instr_done = 0;
      check("R9 req after instr", irq_req, 1);
      check("R9 idx after instr", irq_idx, 5);

      // R10 immediate software clear
      gie_clr = 1; #1;
      check("R10 req dropped same cycle", irq_req, 0);
      tick(); gie_clr = 0;
      check("R10 gie cleared", gie, 0);

      // R4 clear beats set
      gie_set = 1; gie_clr = 1; tick(); gie_set = 0; gie_clr = 0;
      check("R4 clr wins over set", gie, 0);

      // R6 software clears
      sw_clr_wr = 1; sw_clr_data = 8'h01; tick();
      check("R6 zero bits keep flag", flags, 8'h10);
      sw_clr_data = 8'h10; src_in = 8'h10; tick(); src_in = 0;
      check("R6 event wins over clear", flags, 8'h10);
      tick(); sw_clr_wr = 0; sw_clr_data = 0;
      check("R6 write one clears", flags, 8'h00);

      // R8 level source lost when dropped, live when held
      clean();
      src_in = 8'h40; tick(); src_in = 0; tick();
      src_en = 8'h40; #1;
      check("R8 dropped level lost", irq_req, 0);
      check("R8 level sets no flag", flags, 0);
      src_in = 8'h40; #1;
      check("R8 live level req", irq_req, 1);
      check("R8 live level idx", irq_idx, 7);

      // R3 ack with nothing pending is ignored
      src_in = 0; src_en = 0; ack = 1; tick(); ack = 0;
      check("R3 idle ack keeps gie", gie, 1);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule